// File: doc/BRIEF.md
# Vertical Sync Extractor

This block recovers the vertical sync timing from an active-low composite sync stream that is sampled on a system clock. It measures the length of every asserted stretch of sync with a saturating counter. Horizontal sync and equalization pulses are short, so they never climb far. The broad pulses of a vertical interval run long enough to cross an arming level. The block arms at the end of such a broad pulse, which is the moment a serration begins. It then drives a vertical sync pulse whose length is eight ticks of a programmable tick generator.

A second, higher level starts the pulse part-way through a long asserted stretch. This covers vertical intervals that carry no serrations. Because the output latch can be set again once its eight ticks expire, two behaviours are visible at the output. A tick period that is too short yields duplicate pulses on later serrations. A default pulse that ends before the interval closes is followed by a second pulse when the interval ends. The two levels and the tick period are plain configuration inputs, held steady while the block runs.

Top module: `vsync_extractor`

## Requirements
- R1: While `rst` is high and after its release, `vsync` stays low until a trigger occurs; an idle-high input never produces a pulse.
- R2: An asserted (low) run of L consecutive sampled clocks with L >= `arm_level` arms the block at the run's end. `vsync` rises on the third rising clock edge counted from, and including, the first edge that samples the input high again. A run with L < `arm_level` has no effect at the output.
- R3: When a low run reaches `dflt_level` consecutive low samples, a pulse starts. `vsync` rises on the third rising edge after the edge that samples the `dflt_level`-th low. This path fires at most once per low run.
- R4: A pulse started from idle lasts exactly 8 × `tick_period` clocks; a `tick_period` of 0 acts as 1.
- R5: A trigger that arrives while a pulse runs, other than in its final cycle, is ignored, and the pulse ends at its original time.
- R6: A trigger that arrives in the final cycle of a pulse keeps `vsync` high and starts a fresh count of 8 × `tick_period` clocks.
- R7: A trigger that arrives after a pulse has ended starts a new pulse. This produces duplicate pulses on serrations that outlast a short pulse, and a second pulse at the close of an unserrated interval whose default pulse has already ended.
- R8: When the arming and default paths trigger in the same cycle (a low run of exactly `dflt_level` clocks), one pulse of 8 × `tick_period` clocks results.
- R9: An `arm_level` of zero disables the arming path and a `dflt_level` of zero disables the default path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csync_n | input | 1 | Composite sync, asserted low, asynchronous to `clk` |
| arm_level | input | CNT_W | Low-run length that arms the block at the run's end; 0 disables |
| dflt_level | input | CNT_W | Low-run length that starts a default pulse; 0 disables |
| tick_period | input | PER_W | Clocks per tick of the pulse timer; 0 acts as 1 |
| vsync | output | 1 | Vertical sync pulse, active high |

## Verification
The arming trigger and the default trigger can fall in the same cycle, and so can a new trigger and the clear of a running pulse. The first case is provoked by a low run of exactly `dflt_level` clocks. The bench expects one rise at the arming time and a width of exactly 8 × `tick_period`, so a double start or a stretched pulse is caught. The second case is provoked by serrations spaced exactly one pulse width apart, where the bench expects a single merged pulse of the summed length. Randomised runs compare every cycle against a cycle model built from the requirements.

// File: rtl/vsx_pkg.sv
package vsx_pkg;

    // Ticks of the pulse timer that make up one vertical pulse.
    localparam int PULSE_TICKS = 8;

    // Conditioned view of the incoming sync line.
    typedef struct packed {
        logic active;   // sync asserted (line low) after synchronization
        logic closing;  // first cycle after an asserted run ended
    } sync_view_t;

    // Trigger requests toward the pulse latch.
    typedef struct packed {
        logic arm;      // long run ended: serration edge or interval close
        logic dflt;     // run crossed the default level
    } trig_t;

    typedef enum logic {
        PULSE_IDLE = 1'b0,
        PULSE_BUSY = 1'b1
    } pulse_state_t;

    function automatic logic any_trig(input trig_t t);
        return t.arm | t.dflt;
    endfunction

endpackage

// File: rtl/vsx_sync_edge.sv
module vsx_sync_edge
    import vsx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_n,
    output sync_view_t view
);
    localparam int SH_W = (STAGES < 2) ? 2 : STAGES;

    logic [SH_W-1:0] shift_q;
    logic            last_q;

    // Idle level of the line is high; reset there so no false edge appears.
    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '1;
            last_q  <= 1'b1;
        end else begin
            shift_q <= {shift_q[SH_W-2:0], line_n};
            last_q  <= shift_q[SH_W-1];
        end
    end

    always_comb begin
        view.active  = ~shift_q[SH_W-1];
        view.closing = shift_q[SH_W-1] & ~last_q;
    end

endmodule

// File: rtl/vsx_integrator.sv
module vsx_integrator
    import vsx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  sync_view_t       view,
    input  logic [CNT_W-1:0] arm_level,
    input  logic [CNT_W-1:0] dflt_level,
    output trig_t            trig
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_q;
    logic             dflt_seen_q;
    logic             arm_reached;
    logic             dflt_reached;

    always_comb begin
        arm_reached  = (arm_level  != '0) && (run_q >= arm_level);
        dflt_reached = (dflt_level != '0) && (run_q >= dflt_level);
        trig.arm     = view.closing & arm_reached;
        trig.dflt    = dflt_reached & ~dflt_seen_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q       <= '0;
            dflt_seen_q <= 1'b0;
        end else begin
            if (view.active) begin
                if (run_q != CNT_MAX) begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
            dflt_seen_q <= dflt_reached;
        end
    end

    // The run length only falls to zero after the line was seen released.
    AST_RUN_CLEARS_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ($past(run_q) != '0 && run_q == '0) |-> !$past(view.active)); // R2

    // The default request is a single-cycle event per crossing.
    AST_DFLT_SINGLE_SHOT: assert property (@(posedge clk) disable iff (rst)
        trig.dflt |=> !trig.dflt); // R3

endmodule

// File: rtl/vsx_pulse_timer.sv
module vsx_pulse_timer
    import vsx_pkg::*;
#(
    parameter int PER_W = 16,
    parameter int TICKS = PULSE_TICKS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_req,
    input  logic [PER_W-1:0] tick_period,
    output logic             pulse
);
    localparam int DIV_W = (TICKS < 2) ? 1 : $clog2(TICKS);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICKS - 1);

    pulse_state_t     state_q;
    logic [PER_W-1:0] tick_cnt_q;
    logic [DIV_W-1:0] div_q;
    logic [PER_W-1:0] period_eff;
    logic             busy;
    logic             tick;
    logic             finish;

    always_comb begin
        period_eff = (tick_period == '0) ? PER_W'(1) : tick_period;
        busy       = (state_q == PULSE_BUSY);
        tick       = busy && (tick_cnt_q >= period_eff - 1'b1);
        finish     = tick && (div_q == DIV_LAST);
        pulse      = busy;
    end

    // A set request in the clearing cycle wins and restarts the count.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= PULSE_IDLE;
            tick_cnt_q <= '0;
            div_q      <= '0;
        end else if (set_req && (!busy || finish)) begin
            state_q    <= PULSE_BUSY;
            tick_cnt_q <= '0;
            div_q      <= '0;
        end else if (finish) begin
            state_q    <= PULSE_IDLE;
            tick_cnt_q <= '0;
            div_q      <= '0;
        end else if (busy) begin
            if (tick) begin
                tick_cnt_q <= '0;
                div_q      <= div_q + 1'b1;
            end else begin
                tick_cnt_q <= tick_cnt_q + 1'b1;
            end
        end
    end

    AST_IDLE_SET_STARTS: assert property (@(posedge clk) disable iff (rst)
        (!busy && set_req) |=> busy && div_q == '0 && tick_cnt_q == '0); // R7

    AST_PULSE_ENDS_AFTER_LAST_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(div_q) == DIV_LAST && $past(tick))); // R4

    AST_BUSY_SET_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && set_req && !finish) |=> busy && div_q == $past(div_q) + DIV_W'($past(tick))); // R5

    AST_FINAL_SET_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        (finish && set_req) |=> busy && div_q == '0 && tick_cnt_q == '0); // R6

endmodule

// File: rtl/vsync_extractor.sv
module vsync_extractor
    import vsx_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PER_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csync_n,
    input  logic [CNT_W-1:0] arm_level,
    input  logic [CNT_W-1:0] dflt_level,
    input  logic [PER_W-1:0] tick_period,
    output logic             vsync
);
    sync_view_t view;
    trig_t      trig;
    logic       set_req;

    vsx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .line_n (csync_n),
        .view   (view)
    );

    vsx_integrator #(.CNT_W(CNT_W)) u_integ (
        .clk        (clk),
        .rst        (rst),
        .view       (view),
        .arm_level  (arm_level),
        .dflt_level (dflt_level),
        .trig       (trig)
    );

    assign set_req = any_trig(trig);

    vsx_pulse_timer #(.PER_W(PER_W), .TICKS(PULSE_TICKS)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .set_req     (set_req),
        .tick_period (tick_period),
        .pulse       (vsync)
    );

    AST_NO_PULSE_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> !vsync); // R1

endmodule

// File: tb/vsync_extractor_tb.sv
module vsync_extractor_tb;
    localparam int CNT_W = 16;
    localparam int PER_W = 16;
    localparam int RUN_MAX = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             csync_n = 1'b1;
    logic [CNT_W-1:0] arm_lv = 16;
    logic [CNT_W-1:0] dflt_lv = 80;
    logic [PER_W-1:0] per = 2;
    logic             vsync;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    vsync_extractor #(.CNT_W(CNT_W), .PER_W(PER_W)) u_dut (
        .clk(clk), .rst(rst), .csync_n(csync_n),
        .arm_level(arm_lv), .dflt_level(dflt_lv), .tick_period(per),
        .vsync(vsync)
    );

    // Cycle model written from the requirements.
    int       m_run;
    bit       m_prev;
    bit [2:0] m_pend;
    bit       m_v;
    int       m_rem;

    always @(posedge clk) begin
        bit set_now;
        int width;
        if (rst) begin
            m_run = 0; m_prev = 1'b1; m_pend = '0; m_v = 1'b0; m_rem = 0;
        end else begin
            width   = 8 * ((per == 0) ? 1 : int'(per));
            set_now = m_pend[0];
            m_pend  = m_pend >> 1;
            if (csync_n) begin
                if (!m_prev && arm_lv != 0 && m_run >= int'(arm_lv)) m_pend[1] = 1'b1; // R2
                m_run = 0;
            end else begin
                if (m_run < RUN_MAX) m_run++;
                if (dflt_lv != 0 && m_run == int'(dflt_lv)) m_pend[2] = 1'b1;       // R3
            end
            m_prev = csync_n;
            if (m_v) begin
                if (m_rem == 1) begin
                    if (set_now) m_rem = width; else m_v = 1'b0;                   // R6
                end else begin
                    m_rem--;                                                       // R5
                end
            end else if (set_now) begin
                m_v = 1'b1; m_rem = width;
            end
        end
    end

    int mism, dut_rises, mod_rises, hi_cycles;
    bit dv_q, mv_q;

    always @(negedge clk) begin
        if (!rst) begin
            if (vsync !== m_v) mism++;
            if (vsync && !dv_q) dut_rises++;
            if (m_v && !mv_q) mod_rises++;
            if (vsync) hi_cycles++;
            dv_q = vsync;
            mv_q = m_v;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic restart(input int a, input int d, input int p);
        @(negedge clk);
        csync_n = 1'b1;
        arm_lv = CNT_W'(a); dflt_lv = CNT_W'(d); per = PER_W'(p);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        mism = 0; dut_rises = 0; mod_rises = 0; hi_cycles = 0;
        dv_q = 1'b0; mv_q = 1'b0;
    endtask

    task automatic hold(input bit lvl, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            csync_n = lvl;
        end
    endtask

    task automatic normal_line(); hold(0, 5);  hold(1, 59); endtask
    task automatic eq_half();     hold(0, 2);  hold(1, 30); endtask
    task automatic broad_half();  hold(0, 27); hold(1, 5);  endtask

    task automatic frame(input bit serrated);
        repeat (3) normal_line();
        repeat (6) eq_half();
        if (serrated) repeat (6) broad_half();
        else begin hold(0, 192); hold(1, 30); end
        repeat (6) eq_half();
        repeat (3) normal_line();
    endtask

    // Rise check: release the line, expect low after two edges, high after three.
    task automatic release_and_check_rise(input string req);
        @(negedge clk); csync_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); chk(vsync == 1'b0, req, vsync, 0);
        @(posedge clk);
        @(negedge clk); chk(vsync == 1'b1, req, vsync, 1);
    endtask

    function automatic int measure_expected_width(input int p);
        return 8 * ((p == 0) ? 1 : p);
    endfunction

    task automatic count_width(output int w);
        w = 0;
        while (vsync && w < 100000) begin
            w++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int w;
        void'($urandom(32'd4242));

        // R1: reset and idle
        restart(16, 80, 2);
        @(negedge clk);
        chk(vsync == 1'b0, "R1 reset", vsync, 0);
        hold(1, 200);
        chk(dut_rises == 0, "R1 idle", dut_rises, 0);

        // R2/R4: arming timing and width
        restart(16, 80, 2);
        hold(1, 5); hold(0, 20);
        release_and_check_rise("R2 arm rise");
        count_width(w);
        chk(w == 16, "R4 width", w, 16);

        // R2: run one below the level, then exactly at it
        restart(16, 80, 2);
        hold(0, 15); hold(1, 100);
        chk(dut_rises == 0, "R2 below level", dut_rises, 0);
        hold(0, 16);
        release_and_check_rise("R2 at level");
        hold(1, 60);
        chk(dut_rises == 1 && mism == 0, "R2 at level count", dut_rises, 1);

        // R3/R7: default start, then retrigger at interval close
        restart(16, 80, 2);
        hold(1, 5);
        @(negedge clk); csync_n = 1'b0;
        repeat (82) @(posedge clk);
        @(negedge clk); chk(vsync == 1'b0, "R3 default early", vsync, 0);
        @(posedge clk);
        @(negedge clk); chk(vsync == 1'b1, "R3 default rise", vsync, 1);
        hold(0, 200); hold(1, 100);
        chk(dut_rises == 2, "R7 close retrigger", dut_rises, 2);
        chk(mism == 0, "R3 once per run", mism, 0);

        // R8: arm and default in the same cycle
        restart(16, 80, 2);
        hold(1, 5); hold(0, 80);
        release_and_check_rise("R8 coincident rise");
        count_width(w);
        chk(w == 16, "R8 single width", w, 16);
        hold(1, 50);
        chk(dut_rises == 1, "R8 one pulse", dut_rises, 1);

        // R4: zero tick period acts as one
        restart(16, 80, 0);
        hold(0, 20); hold(1, 60);
        chk(hi_cycles == 8, "R4 zero period", hi_cycles, 8);

        // R5: long pulse covers all serrations
        restart(16, 80, 24);
        frame(1'b1);
        chk(dut_rises == 1 && hi_cycles == 192, "R5 serrated covered", dut_rises, 1);

        // R6: triggers land on the clearing cycle and merge
        restart(16, 80, 4);
        frame(1'b1);
        chk(dut_rises == 1, "R6 merged count", dut_rises, 1);
        chk(hi_cycles == 192, "R6 merged width", hi_cycles, 192);

        // R7: short pulse gives duplicates on later serrations
        restart(16, 80, 3);
        frame(1'b1);
        chk(dut_rises == 6, "R7 duplicates", dut_rises, 6);

        // R5/R7: unserrated interval, long and short pulse
        restart(16, 80, 24);
        frame(1'b0);
        chk(dut_rises == 1 && mism == 0, "R5 unserrated long", dut_rises, 1);
        restart(16, 80, 8);
        frame(1'b0);
        chk(dut_rises == 2 && mism == 0, "R7 unserrated short", dut_rises, 2);

        // R9: zero levels disable their paths
        restart(0, 80, 2);
        hold(0, 40); hold(1, 80);
        chk(dut_rises == 0, "R9 arm off", dut_rises, 0);
        restart(16, 0, 2);
        hold(0, 300); hold(1, 80);
        chk(dut_rises == 1 && mism == 0, "R9 default off", dut_rises, 1);

        // Random runs against the model (R2 R3 R5 R6 R7)
        for (int r = 0; r < 6; r++) begin
            restart(int'($urandom_range(20, 10)), int'($urandom_range(120, 60)),
                    int'($urandom_range(30, 1)));
            for (int s = 0; s < 80; s++) begin
                hold(0, int'($urandom_range(150, 1)));
                hold(1, int'($urandom_range(60, 1)));
            end
            hold(1, 300);
            chk(mism == 0, "R2 R3 random cycles", mism, 0);
            chk(dut_rises == mod_rises, "R7 random pulses", dut_rises, mod_rises);
        end
        for (int r = 0; r < 4; r++) begin
            restart(16, 80, int'($urandom_range(30, 2)));
            frame(1'($urandom_range(1, 0)));
            chk(mism == 0 && dut_rises == mod_rises, "R5 R6 random frame", dut_rises, mod_rises);
        end

        finish_run();
    end

endmodule